// File: doc/BRIEF.md
# Bicolor LED Matrix Scan Driver

This block lights a small matrix of two-lead bicolor LEDs wired between shared column wires and shared line wires. Each LED shows green or red depending on which way current flows through it, so a single LED position has four looks: dark, green, red, or orange. Orange is produced by alternating the two polarities. The block receives a packed word with a 2-bit colour code for every LED and a brightness value in percent. It scans one column at a time at a fixed frame rate and drives the column levels, the line levels and one output enable per line. When a line's enable is low, that line floats.

Each column gets a time slot of equal length. Within the slot, only the leading fraction given by the brightness is lit, and the rest of the slot is dark. The lit part is split into two halves. In the first half the active column is high, and lines that want green are pulled low. In the second half the column levels are inverted, and lines that want red are driven high. A line whose LED should be dark in the current slot is released for the whole slot.

The colour word and brightness are plain level inputs with no handshake. They are captured once per slot, so a change never shows up partway through a slot. The block's only data path runs outward to the LED pins, which cannot stall, so there is no back-pressure anywhere.

Top module: `bcled_scan_driver`

## Requirements
- R1: Colour codes are 2'b00 dark, 2'b01 green, 2'b10 red and 2'b11 orange. The LED at line L, column C takes its code from bits [2k+1:2k] of the state word, where k = L*NUM_COL + (NUM_COL-1-C). With the default 4x2 matrix, bits 7:6 therefore hold line 0 / column 0 and bits 15:14 hold line 1 / column 0.
- R2: A slot lasts SLOT = CLK_HZ/(REFRESH_HZ*NUM_COL) cycles, and columns are served in ascending order with wrap-around. All outputs are registered: after the n-th rising edge following reset release, the outputs show scan position p = n-1. That position is cycle p mod SLOT of the slot for column (p div SLOT) mod NUM_COL.
- R3: The lit time of a slot is ON = floor(SLOT*I/100) cycles, where I is the captured brightness. Slot cycles at or beyond ON are dark: the column bus is all zero, every line enable is low and every line level is low. A brightness of 0 gives a fully dark slot.
- R4: The green phase covers slot cycles below floor(ON/2). In it, only the active column is high, and every line whose LED code is green or orange is enabled and driven low.
- R5: The red phase covers slot cycles from floor(ON/2) up to ON. In it, the active column is low and all other columns are high, and every line whose LED code is red or orange is enabled and driven high.
- R6: A line not enabled in the current phase has its enable low and its level low. In particular, a line whose LED is coded dark is never enabled during that slot.
- R7: The state word and brightness are captured only at the clock edge that ends a slot. A change between those edges has no effect on the outputs until the next slot.
- R8: The reset is asynchronous and active low. While it is low, the column bus, line levels and line enables are all zero. After release, the scan restarts at column 0, and the whole first slot is dark because nothing has been captured yet.
- R9: Lines are independent: each line's enable and level depend only on its own LED code in the active column.
- R10: A brightness above 100 behaves exactly like 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Scan clock at CLK_HZ |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| led_state_i | input | 2*NUM_COL*NUM_LINE | Packed 2-bit colour codes, one per LED |
| intensity_i | input | 7 | Brightness in percent; values above 100 act as 100 |
| col_o | output | NUM_COL | Column levels |
| line_o | output | NUM_LINE | Line levels |
| line_en_o | output | NUM_LINE | Per-line output enable; low releases the line |

## Verification
The bench builds the block with NUM_COL=4, NUM_LINE=2, CLK_HZ=100000 and REFRESH_HZ=250, which makes each slot exactly 100 cycles long. With that slot length one percent of brightness is one cycle, so the boundaries at 0, 1, 99, 100 and above 100 land on exact cycles. A whole frame is only 400 cycles, so dozens of frames fit in the run. Mid-slot input changes, a mid-run reset and random colour words therefore all exercise the capture timing, both phase edges and every column wrap, with every output compared cycle by cycle.

// File: rtl/bcl_pkg.sv
package bcl_pkg;

  typedef enum logic [1:0] {
    COLOR_DARK   = 2'b00,
    COLOR_GREEN  = 2'b01,
    COLOR_RED    = 2'b10,
    COLOR_ORANGE = 2'b11
  } color_e;

  typedef enum logic [1:0] {
    PH_DARK  = 2'd0,
    PH_GREEN = 2'd1,
    PH_RED   = 2'd2
  } phase_e;

  function automatic logic wants_green(input color_e c);
    return (c == COLOR_GREEN) || (c == COLOR_ORANGE);
  endfunction

  function automatic logic wants_red(input color_e c);
    return (c == COLOR_RED) || (c == COLOR_ORANGE);
  endfunction

endpackage

// File: rtl/bcl_scan_timer.sv
module bcl_scan_timer #(
  parameter int SLOT    = 62500,
  parameter int NUM_COL = 4,
  parameter int CNT_W   = $clog2(SLOT),
  parameter int COL_W   = (NUM_COL > 1) ? $clog2(NUM_COL) : 1
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [COL_W-1:0] col_o,
  output logic             slot_end_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [COL_W-1:0] col_q;

  assign slot_end_o = (cnt_q == CNT_LAST);
  assign cnt_o      = cnt_q;
  assign col_o      = col_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
      col_q <= '0;
    end else if (slot_end_o) begin
      cnt_q <= '0;
      col_q <= (col_q == COL_LAST) ? '0 : col_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: slot counter stays inside the slot
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q <= CNT_LAST);

  // R2: column index stays inside the matrix
  a_r2_col_bound: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    col_q <= COL_LAST);

  // R2: the end of a slot restarts the count and moves to the next column
  a_r2_col_advance: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    slot_end_o |=> (cnt_q == '0) &&
                   (col_q == (($past(col_q) == COL_LAST) ? '0 : $past(col_q) + 1'b1)));

endmodule

// File: rtl/bcl_frame_latch.sv
module bcl_frame_latch #(
  parameter int SLOT    = 62500,
  parameter int STATE_W = 16,
  parameter int PCT_W   = 7,
  parameter int ON_W    = $clog2(SLOT + 1)
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               load_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic [PCT_W-1:0]   pct_i,
  output logic [STATE_W-1:0] state_o,
  output logic [ON_W-1:0]    on_o,
  output logic [ON_W-1:0]    half_o
);

  localparam int             PROD_W  = ON_W + PCT_W;
  localparam logic [PCT_W-1:0] PCT_MAX = PCT_W'(100);

  logic [PCT_W-1:0]   pct_clamped;
  logic [PROD_W-1:0]  prod;
  logic [ON_W-1:0]    on_next;
  logic [STATE_W-1:0] state_q;
  logic [ON_W-1:0]    on_q;
  logic [ON_W-1:0]    half_q;

  always_comb begin
    pct_clamped = (pct_i > PCT_MAX) ? PCT_MAX : pct_i;
    prod        = PROD_W'(SLOT) * PROD_W'(pct_clamped);
    on_next     = ON_W'(prod / PROD_W'(100));
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= '0;
      on_q    <= '0;
      half_q  <= '0;
    end else if (load_i) begin
      state_q <= state_i;
      on_q    <= on_next;
      half_q  <= on_next >> 1;
    end
  end

  assign state_o = state_q;
  assign on_o    = on_q;
  assign half_o  = half_q;

  // R7: captured values hold steady between slot boundaries
  a_r7_hold_mid_slot: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !load_i |=> $stable(state_q) && $stable(on_q) && $stable(half_q));

  // R10: lit time never exceeds the slot, whatever the brightness input
  a_r10_on_capped: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    on_q <= ON_W'(SLOT));

  // R4: the green half never exceeds the lit time
  a_r4_half_within_on: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    half_q <= on_q);

endmodule

// File: rtl/bcl_col_drive.sv
module bcl_col_drive #(
  parameter int NUM_COL = 4,
  parameter int COL_W   = (NUM_COL > 1) ? $clog2(NUM_COL) : 1
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  bcl_pkg::phase_e    phase_i,
  input  logic [COL_W-1:0]   col_i,
  output logic [NUM_COL-1:0] col_bus_o
);

  import bcl_pkg::*;

  logic [NUM_COL-1:0] sel;
  logic [NUM_COL-1:0] bus_next;
  logic [NUM_COL-1:0] bus_q;

  always_comb begin
    sel = '0;
    sel[col_i] = 1'b1;
    case (phase_i)
      PH_GREEN: bus_next = sel;
      PH_RED:   bus_next = ~sel;
      default:  bus_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) bus_q <= '0;
    else          bus_q <= bus_next;
  end

  assign col_bus_o = bus_q;

  // R3: a dark cycle leaves every column low
  a_r3_dark_columns: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (phase_i == PH_DARK) |=> (col_bus_o == '0));

  // R4: in the green phase exactly one column is high
  a_r4_one_column_high: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (phase_i == PH_GREEN) |=> $onehot(col_bus_o));

endmodule

// File: rtl/bcl_line_drive.sv
module bcl_line_drive #(
  parameter int NUM_COL  = 4,
  parameter int NUM_LINE = 2,
  parameter int COL_W    = (NUM_COL > 1) ? $clog2(NUM_COL) : 1,
  parameter int STATE_W  = 2 * NUM_COL * NUM_LINE
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  bcl_pkg::phase_e     phase_i,
  input  logic [COL_W-1:0]    col_i,
  input  logic [STATE_W-1:0]  state_i,
  output logic [NUM_LINE-1:0] line_o,
  output logic [NUM_LINE-1:0] line_en_o
);

  import bcl_pkg::*;

  localparam int NUM_LED = NUM_COL * NUM_LINE;
  localparam int IDX_W   = (NUM_LED > 1) ? $clog2(NUM_LED) : 1;

  for (genvar g = 0; g < NUM_LINE; g++) begin : g_line
    logic [IDX_W-1:0] led_idx;
    color_e           code;
    logic             en_next;
    logic             lvl_next;
    logic             en_q;
    logic             lvl_q;

    always_comb begin
      led_idx = IDX_W'(g * NUM_COL + NUM_COL - 1) - IDX_W'(col_i);
      code    = color_e'(state_i[{led_idx, 1'b0} +: 2]);
      case (phase_i)
        PH_GREEN: begin
          en_next  = wants_green(code);
          lvl_next = 1'b0;
        end
        PH_RED: begin
          en_next  = wants_red(code);
          lvl_next = wants_red(code);
        end
        default: begin
          en_next  = 1'b0;
          lvl_next = 1'b0;
        end
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        en_q  <= 1'b0;
        lvl_q <= 1'b0;
      end else begin
        en_q  <= en_next;
        lvl_q <= lvl_next;
      end
    end

    assign line_en_o[g] = en_q;
    assign line_o[g]    = lvl_q;

    // R4: a line enabled in the green phase pulls low
    a_r4_green_pulls_low: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (phase_i == PH_GREEN) |=> !line_o[g]);

    // R3: dark cycles release every line
    a_r3_dark_release: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (phase_i == PH_DARK) |=> !line_en_o[g]);

    // R6: a line that is released sits at a low level
    a_r6_released_low: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !line_en_o[g] |-> !line_o[g]);
  end

endmodule

// File: rtl/bcled_scan_driver.sv
module bcled_scan_driver #(
  parameter int NUM_COL    = 4,
  parameter int NUM_LINE   = 2,
  parameter int CLK_HZ     = 62_500_000,
  parameter int REFRESH_HZ = 250
) (
  input  logic                            clk_i,
  input  logic                            rst_n_i,
  input  logic [2*NUM_COL*NUM_LINE-1:0]   led_state_i,
  input  logic [6:0]                      intensity_i,
  output logic [NUM_COL-1:0]              col_o,
  output logic [NUM_LINE-1:0]             line_o,
  output logic [NUM_LINE-1:0]             line_en_o
);

  import bcl_pkg::*;

  localparam int SLOT    = CLK_HZ / (REFRESH_HZ * NUM_COL);
  localparam int CNT_W   = (SLOT > 1) ? $clog2(SLOT) : 1;
  localparam int ON_W    = $clog2(SLOT + 1);
  localparam int COL_W   = (NUM_COL > 1) ? $clog2(NUM_COL) : 1;
  localparam int STATE_W = 2 * NUM_COL * NUM_LINE;
  localparam int PCT_W   = 7;

  logic [CNT_W-1:0]   cnt;
  logic [COL_W-1:0]   col;
  logic               slot_end;
  logic [STATE_W-1:0] state_cap;
  logic [ON_W-1:0]    on_len;
  logic [ON_W-1:0]    half_len;
  logic [ON_W-1:0]    pos;
  phase_e             phase;

  bcl_scan_timer #(
    .SLOT    (SLOT),
    .NUM_COL (NUM_COL),
    .CNT_W   (CNT_W),
    .COL_W   (COL_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .cnt_o      (cnt),
    .col_o      (col),
    .slot_end_o (slot_end)
  );

  bcl_frame_latch #(
    .SLOT    (SLOT),
    .STATE_W (STATE_W),
    .PCT_W   (PCT_W),
    .ON_W    (ON_W)
  ) u_latch (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .load_i  (slot_end),
    .state_i (led_state_i),
    .pct_i   (intensity_i),
    .state_o (state_cap),
    .on_o    (on_len),
    .half_o  (half_len)
  );

  always_comb begin
    pos = ON_W'(cnt);
    if (pos < half_len)    phase = PH_GREEN;
    else if (pos < on_len) phase = PH_RED;
    else                   phase = PH_DARK;
  end

  bcl_col_drive #(
    .NUM_COL (NUM_COL),
    .COL_W   (COL_W)
  ) u_cols (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .phase_i   (phase),
    .col_i     (col),
    .col_bus_o (col_o)
  );

  bcl_line_drive #(
    .NUM_COL  (NUM_COL),
    .NUM_LINE (NUM_LINE),
    .COL_W    (COL_W),
    .STATE_W  (STATE_W)
  ) u_lines (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .phase_i   (phase),
    .col_i     (col),
    .state_i   (state_cap),
    .line_o    (line_o),
    .line_en_o (line_en_o)
  );

  // R4: a line pulled low while enabled sees exactly one high column
  a_r4_green_polarity: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (|(line_en_o & ~line_o)) |-> ($countones(col_o) == 1));

  // R5: a line driven high while enabled sees exactly one low column
  a_r5_red_polarity: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (|(line_en_o & line_o)) |-> ($countones(col_o) == NUM_COL - 1));

  // R8: reset leaves every line released on the following edge
  a_r8_reset_release: assert property (@(posedge clk_i)
    !rst_n_i |=> (line_en_o == '0));

endmodule

// File: tb/bcled_scan_driver_tb.sv
`timescale 1ns/1ps
module bcled_scan_driver_tb;

  localparam int NC     = 4;
  localparam int NL     = 2;
  localparam int CLK_HZ = 100_000;
  localparam int RHZ    = 250;
  localparam int SLOT   = CLK_HZ / (RHZ * NC);
  localparam int SW     = 2 * NC * NL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] st_in = '0;
  logic [6:0]    pct_in = '0;
  logic [NC-1:0] col_o;
  logic [NL-1:0] line_o;
  logic [NL-1:0] line_en_o;

  int checks = 0;
  int errors = 0;
  int n = 0;
  logic [SW-1:0] snap_st = '0;
  int            snap_pct = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  bcled_scan_driver #(
    .NUM_COL    (NC),
    .NUM_LINE   (NL),
    .CLK_HZ     (CLK_HZ),
    .REFRESH_HZ (RHZ)
  ) u_dut (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .led_state_i (st_in),
    .intensity_i (pct_in),
    .col_o       (col_o),
    .line_o      (line_o),
    .line_en_o   (line_en_o)
  );

  // Expected outputs for scan position p (R1..R6, R10)
  task automatic model(input int p, input logic [SW-1:0] st, input int pct,
                       output logic [NC-1:0] ec, output logic [NL-1:0] el,
                       output logic [NL-1:0] ee, output int ph);
    int k, c, pc, on, half;
    k = p % SLOT;
    c = (p / SLOT) % NC;
    pc = (pct > 100) ? 100 : pct;
    on = (SLOT * pc) / 100;
    half = on / 2;
    ec = '0; el = '0; ee = '0;
    if (k < half) ph = 1;
    else if (k < on) ph = 2;
    else ph = 0;
    for (int l = 0; l < NL; l++) begin
      logic [1:0] code;
      code = 2'((st >> (2 * (l * NC + NC - 1 - c))) & 2'b11);
      if (ph == 1 && (code == 2'b01 || code == 2'b11)) ee[l] = 1'b1;
      if (ph == 2 && (code == 2'b10 || code == 2'b11)) begin
        ee[l] = 1'b1;
        el[l] = 1'b1;
      end
    end
    if (ph == 1) ec[c] = 1'b1;
    if (ph == 2) begin
      ec = '1;
      ec[c] = 1'b0;
    end
  endtask

  task automatic check_val(input string tag, input string what, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s pos=%0d actual=%0h expected=%0h", tag, what, n - 1, act, exp_v);
    end
  endtask

  task automatic check_pos();
    logic [NC-1:0] ec;
    logic [NL-1:0] el, ee;
    int ph;
    string ovr, t_en;
    model(n - 1, snap_st, snap_pct, ec, el, ee, ph);
    ovr = "";
    if (n - 1 < SLOT) ovr = "R8";
    else if (st_in != snap_st || int'(pct_in) != snap_pct) ovr = "R7";
    else if (snap_pct > 100) ovr = "R10";
    if (ph == 0) t_en = "R3";
    else if (ee != '1) t_en = "R6";
    else if (ph == 1) t_en = "R4";
    else t_en = "R5";
    check_val((ovr != "") ? ovr : "R2", "col", int'(col_o), int'(ec));
    check_val((ovr != "") ? ovr : t_en, "line_en", int'(line_en_o), int'(ee));
    check_val((ovr != "") ? ovr : ((NL > 1) ? "R9" : "R1"), "line", int'(line_o), int'(el));
  endtask

  task automatic run(input int cycles, input bit rnd);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      check_pos();
      if (n % SLOT == 0) begin
        snap_st = st_in;
        snap_pct = int'(pct_in);
      end
      if (rnd && $urandom_range(39) == 0) begin
        st_in = SW'($urandom);
        pct_in = 7'($urandom_range(127));
      end
    end
  endtask

  task automatic check_reset_state();
    check_val("R8", "col_rst", int'(col_o), 0);
    check_val("R8", "en_rst", int'(line_en_o), 0);
    check_val("R8", "line_rst", int'(line_o), 0);
  endtask

  task automatic segment(input logic [SW-1:0] st, input int pct, input int frames);
    st_in = st;
    pct_in = 7'(pct);
    run(frames * SLOT * NC, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) begin
      @(negedge clk);
      check_reset_state();
    end
    st_in = SW'($urandom);
    pct_in = 7'd100;
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    run(SLOT * NC, 1'b0);                  // R8: first slot dark, then full brightness
    segment(SW'($urandom), 100, 2);        // R4 R5 full-width phases
    segment(16'hFFFF, 50, 1);              // R1 all orange
    segment(SW'($urandom), 0, 1);          // R3 zero brightness
    segment(SW'($urandom), 127, 2);        // R10 above 100
    segment(SW'($urandom), 1, 1);          // R3 one lit cycle, red only
    segment(SW'($urandom), 99, 1);         // odd lit time
    segment(16'h5555, 75, 1);              // R1 all green
    segment(16'hAAAA, 33, 1);              // R1 all red
    segment(16'h00C3, 64, 1);              // R6 mixed dark positions
    run(8 * SLOT * NC, 1'b1);              // R7 random mid-slot changes
    // mid-run reset, R8
    @(negedge clk);
    rst_n = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check_reset_state();
    end
    rst_n = 1'b1;
    n = 0;
    snap_st = '0;
    snap_pct = 0;
    run(3 * SLOT * NC, 1'b1);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired at pos=%0d actual=running expected=finished", n);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule